// File: doc/BRIEF.md
# Masked GPIO Output Controller

This block is the output stage for a bank of general-purpose I/O lines. It holds an output data latch that software changes in three ways: a set register raises the bits written as 1, a clear register lowers them, and a direct data write replaces the latch contents. The direct write only reaches the bits that a separate write-authorization mask allows. Software can therefore raise some lines and lower others in one bus write, with no read-modify-write, while leaving the other lines alone.

Each line has a per-line select input that hands the line either to the GPIO latch and the GPIO output-enable register, or to a peripheral's value and enable signals. After that choice, an optional per-line open-drain mode is applied. A line in that mode only ever drives low, and releases its output-enable whenever its value is 1. The mask, the open-drain configuration and the GPIO output-enable are each changed through an enable/disable register pair and read back at a status address. The pin outputs and the read data are registered.

Top module: `gpio_mask_out`

## Requirements
- R1: A write to the set address (0x0) makes every latch bit whose write-data bit is 1 equal to 1, and leaves the bits written as 0 unchanged.
- R2: A write to the clear address (0x1) makes every latch bit whose write-data bit is 1 equal to 0, and leaves the bits written as 0 unchanged.
- R3: A write to the data address (0x2) copies write-data into the latch only where the authorization mask bit is 1. Every other latch bit keeps its value.
- R4: The authorization mask gains bits through address 0x3 and loses bits through address 0x4 (a 1 in the write data selects the bit) and reads back at 0x5. It resets to zero, so direct data writes after reset change nothing.
- R5: Open-drain mode is enabled per line at 0x6, disabled at 0x7 and read back at 0x8. It resets to zero, so every line starts in push-pull mode.
- R6: A line in open-drain mode never has pin_out=1 together with pin_oe=1. When its selected value is 0 it drives pin_out=0 with pin_oe equal to the selected enable. When its selected value is 1 it has pin_oe=0.
- R7: A line with pin_sel=1 takes its value and enable from periph_out and periph_oe, and open-drain mode is applied after this choice. A line with pin_sel=0 uses the latch and the GPIO output-enable register.
- R8: Set and clear writes update the latch while the line is selected to the peripheral. The new latch level is driven as soon as the line returns to GPIO control.
- R9: After reset the latch, mask, open-drain and output-enable registers, pin_out, pin_oe and rdata are all zero.
- R10: A read of address 0x2 returns the latch contents, not the level at the pin. Unmapped addresses read as zero.
- R11: The GPIO output-enable register gains bits at 0x9, loses bits at 0xA and reads back at 0xB.
- R12: pin_out and pin_oe reflect a register write two rising edges after the write is sampled (the register edge, then the pin register edge), and a change of pin_sel or peripheral inputs one edge later. rdata is updated on the edge that samples rd_en and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register bus |
| rd_en | input | 1 | Read strobe; rdata loads on this edge |
| addr | input | 4 | Register address |
| wdata | input | NUM_LINES | Write data, one bit per line |
| rdata | output | NUM_LINES | Registered read data |
| pin_sel | input | NUM_LINES | Per-line select: 1 = peripheral, 0 = GPIO |
| periph_out | input | NUM_LINES | Peripheral output value per line |
| periph_oe | input | NUM_LINES | Peripheral output enable per line |
| pin_out | output | NUM_LINES | Registered pin output value |
| pin_oe | output | NUM_LINES | Registered pin output enable |

## Verification
A corrupted latch or mask bit shows up at pin_out two edges after the write that caused it, provided the line is selected to GPIO, has its enable set and is in push-pull mode. Otherwise it stays hidden at the pins until a readback of the data or mask address shows it one edge after the read. A wrong open-drain bit appears on pin_oe and pin_out only when that line's selected value is 1, so the bench keeps a reference model of every register. It compares both pin buses after every write and every change of select or peripheral input, over long random runs of mask, set, clear, data and mode writes, and reads the status addresses back along the way.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_SET    = 4'h0,
    A_CLR    = 4'h1,
    A_DATA   = 4'h2,
    A_MEN    = 4'h3,
    A_MDIS   = 4'h4,
    A_MSTAT  = 4'h5,
    A_ODEN   = 4'h6,
    A_ODDIS  = 4'h7,
    A_ODSTAT = 4'h8,
    A_OEEN   = 4'h9,
    A_OEDIS  = 4'hA,
    A_OESTAT = 4'hB
  } reg_addr_e;

  typedef struct packed {
    logic set;
    logic clr;
    logic data;
    logic men;
    logic mdis;
    logic oden;
    logic oddis;
    logic oeen;
    logic oedis;
  } wr_strobe_t;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_mask_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output wr_strobe_t        stb
);

  always_comb begin
    stb = '0;
    if (wr_en) begin
      case (reg_addr_e'(addr))
        A_SET:   stb.set   = 1'b1;
        A_CLR:   stb.clr   = 1'b1;
        A_DATA:  stb.data  = 1'b1;
        A_MEN:   stb.men   = 1'b1;
        A_MDIS:  stb.mdis  = 1'b1;
        A_ODEN:  stb.oden  = 1'b1;
        A_ODDIS: stb.oddis = 1'b1;
        A_OEEN:  stb.oeen  = 1'b1;
        A_OEDIS: stb.oedis = 1'b1;
        default: stb = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] set_bits;
  logic [WIDTH-1:0] clr_bits;

  assign set_bits = set_stb ? wdata : '0;
  assign clr_bits = clr_stb ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q | set_bits) & ~clr_bits;
  end

endmodule

// File: rtl/gpio_data_latch.sv
module gpio_data_latch #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic             data_stb,
  input  logic [WIDTH-1:0] auth_mask,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] nxt;

  always_comb begin
    nxt = q;
    if (set_stb)  nxt = nxt | wdata;
    if (clr_stb)  nxt = nxt & ~wdata;
    if (data_stb) nxt = (nxt & ~auth_mask) | (wdata & auth_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] latch,
  input  logic [WIDTH-1:0] gpio_oe,
  input  logic [WIDTH-1:0] sel,
  input  logic [WIDTH-1:0] pv,
  input  logic [WIDTH-1:0] poe,
  input  logic [WIDTH-1:0] od,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic val;
    logic en;

    assign val = sel[i] ? pv[i]  : latch[i];
    assign en  = sel[i] ? poe[i] : gpio_oe[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[i] <= 1'b0;
        pin_oe[i]  <= 1'b0;
      end else if (od[i]) begin
        pin_out[i] <= 1'b0;
        pin_oe[i]  <= en & ~val;
      end else begin
        pin_out[i] <= val;
        pin_oe[i]  <= en;
      end
    end
  end

endmodule

// File: rtl/gpio_mask_out.sv
module gpio_mask_out
  import gpio_mask_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] rdata,
  input  logic [NUM_LINES-1:0] pin_sel,
  input  logic [NUM_LINES-1:0] periph_out,
  input  logic [NUM_LINES-1:0] periph_oe,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe
);

  wr_strobe_t           stb;
  logic [NUM_LINES-1:0] latch_q;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] od_q;
  logic [NUM_LINES-1:0] oe_q;
  logic [NUM_LINES-1:0] rd_mux;

  gpio_reg_decode u_dec (
    .wr_en (wr_en),
    .addr  (addr),
    .stb   (stb)
  );

  gpio_setclr_reg #(.WIDTH(NUM_LINES)) u_mask (
    .clk (clk), .rst (rst),
    .set_stb (stb.men), .clr_stb (stb.mdis),
    .wdata (wdata), .q (mask_q)
  );

  gpio_setclr_reg #(.WIDTH(NUM_LINES)) u_od (
    .clk (clk), .rst (rst),
    .set_stb (stb.oden), .clr_stb (stb.oddis),
    .wdata (wdata), .q (od_q)
  );

  gpio_setclr_reg #(.WIDTH(NUM_LINES)) u_oe (
    .clk (clk), .rst (rst),
    .set_stb (stb.oeen), .clr_stb (stb.oedis),
    .wdata (wdata), .q (oe_q)
  );

  gpio_data_latch #(.WIDTH(NUM_LINES)) u_latch (
    .clk (clk), .rst (rst),
    .set_stb (stb.set), .clr_stb (stb.clr), .data_stb (stb.data),
    .auth_mask (mask_q), .wdata (wdata), .q (latch_q)
  );

  gpio_pin_drive #(.WIDTH(NUM_LINES)) u_pins (
    .clk (clk), .rst (rst),
    .latch (latch_q), .gpio_oe (oe_q),
    .sel (pin_sel), .pv (periph_out), .poe (periph_oe),
    .od (od_q),
    .pin_out (pin_out), .pin_oe (pin_oe)
  );

  always_comb begin
    case (reg_addr_e'(addr))
      A_DATA:   rd_mux = latch_q;
      A_MSTAT:  rd_mux = mask_q;
      A_ODSTAT: rd_mux = od_q;
      A_OESTAT: rd_mux = oe_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

endmodule

// File: rtl/gpio_mask_chk.sv
module gpio_mask_chk
  import gpio_mask_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [NUM_LINES-1:0] wdata,
  input logic [NUM_LINES-1:0] latch,
  input logic [NUM_LINES-1:0] mask,
  input logic [NUM_LINES-1:0] od,
  input logic [NUM_LINES-1:0] pin_out,
  input logic [NUM_LINES-1:0] pin_oe
);

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_SET) |=> ((latch & $past(wdata)) == $past(wdata))); // R1

  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CLR) |=> ((latch & $past(wdata)) == '0)); // R2

  AST_DATA_MASKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_DATA) |=> ((latch & ~$past(mask)) == ($past(latch) & ~$past(mask)))); // R3

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (addr == A_MEN || addr == A_MDIS)) |=> $stable(mask)); // R4

  AST_OD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (addr == A_ODEN || addr == A_ODDIS)) |=> $stable(od)); // R5

  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_out & pin_oe & $past(od)) == '0)); // R6

endmodule

bind gpio_mask_out gpio_mask_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk (clk), .rst (rst), .wr_en (wr_en), .addr (addr), .wdata (wdata),
  .latch (latch_q), .mask (mask_q), .od (od_q),
  .pin_out (pin_out), .pin_oe (pin_oe)
);

// File: tb/gpio_mask_out_tb.sv
module gpio_mask_out_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  typedef struct {
    int          due;
    logic [N-1:0] e_out;
    logic [N-1:0] e_oe;
    bit          has_rd;
    logic [N-1:0] e_rd;
    string       tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [3:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic [N-1:0] pin_sel = '0;
  logic [N-1:0] periph_out = '0;
  logic [N-1:0] periph_oe = '0;
  logic [N-1:0] pin_out;
  logic [N-1:0] pin_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  item_t sb[$];

  logic [N-1:0] m_latch = '0, m_mask = '0, m_od = '0, m_oe = '0;

  gpio_mask_out #(.NUM_LINES(N)) u_dut (
    .clk (clk), .rst (rst), .wr_en (wr_en), .rd_en (rd_en),
    .addr (addr), .wdata (wdata), .rdata (rdata),
    .pin_sel (pin_sel), .periph_out (periph_out), .periph_oe (periph_oe),
    .pin_out (pin_out), .pin_oe (pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_out();
    logic [N-1:0] v;
    v = (pin_sel & periph_out) | (~pin_sel & m_latch);
    return v & ~m_od;
  endfunction

  function automatic logic [N-1:0] exp_oe();
    logic [N-1:0] v, e;
    v = (pin_sel & periph_out) | (~pin_sel & m_latch);
    e = (pin_sel & periph_oe) | (~pin_sel & m_oe);
    return e & ~(m_od & v);
  endfunction

  task automatic push_pins(string tag, int due);
    item_t it;
    it.due = due; it.e_out = exp_out(); it.e_oe = exp_oe();
    it.has_rd = 1'b0; it.e_rd = '0; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: pop scoreboard items when due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      if (it.due < cyc) begin
        checks++; errors++;
        $display("FAIL %s missed sample actual=%0d expected=%0d", it.tag, cyc, it.due);
      end else if (it.has_rd) begin
        check({it.tag, " rdata"}, rdata, it.e_rd);
      end else begin
        check({it.tag, " pin_out"}, pin_out, it.e_out);
        check({it.tag, " pin_oe"}, pin_oe, it.e_oe);
      end
    end
  end

  task automatic bus_wr(logic [3:0] a, logic [N-1:0] d, string tag);
    logic [N-1:0] old_out, old_oe;
    old_out = exp_out(); old_oe = exp_oe();
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    // R12: pins still show the state before the write one edge after it
    check("R12 pin_out lag", pin_out, old_out);
    check("R12 pin_oe lag", pin_oe, old_oe);
    case (a)
      4'h0: m_latch = m_latch | d;
      4'h1: m_latch = m_latch & ~d;
      4'h2: m_latch = (m_latch & ~m_mask) | (d & m_mask);
      4'h3: m_mask = m_mask | d;
      4'h4: m_mask = m_mask & ~d;
      4'h6: m_od = m_od | d;
      4'h7: m_od = m_od & ~d;
      4'h9: m_oe = m_oe | d;
      4'hA: m_oe = m_oe & ~d;
      default: ;
    endcase
    push_pins(tag, cyc + 1);
  endtask

  task automatic bus_rd(logic [3:0] a, string tag);
    item_t it;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    it.due = cyc + 1; it.e_out = '0; it.e_oe = '0; it.has_rd = 1'b1; it.tag = tag;
    case (a)
      4'h2: it.e_rd = m_latch;
      4'h5: it.e_rd = m_mask;
      4'h8: it.e_rd = m_od;
      4'hB: it.e_rd = m_oe;
      default: it.e_rd = '0;
    endcase
    sb.push_back(it);
  endtask

  task automatic drive_pins(logic [N-1:0] s, logic [N-1:0] v, logic [N-1:0] e, string tag);
    @(negedge clk);
    pin_sel = s; periph_out = v; periph_oe = e;
    push_pins(tag, cyc + 1);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset pin_out", pin_out, '0);
    check("R9 reset pin_oe", pin_oe, '0);
    check("R9 reset rdata", rdata, '0);
    bus_rd(4'h2, "R9 latch reset");
    bus_rd(4'h8, "R5 od reset");
    bus_rd(4'hB, "R9 oe reset");
    bus_wr(4'h9, 32'hFFFF_FFFF, "R11 oe enable");
    bus_wr(4'h2, 32'hDEAD_BEEF, "R4 data write with zero mask");
    bus_rd(4'h2, "R4 latch unchanged");
    bus_wr(4'h3, 32'h0000_FFFF, "R4 mask enable");
    bus_rd(4'h5, "R4 mask status");
    bus_wr(4'h2, 32'hA5A5_A5A5, "R3 masked data write");
    bus_rd(4'h2, "R3 latch");
    bus_wr(4'h0, 32'hF000_0000, "R1 set");
    bus_wr(4'h1, 32'h0000_A000, "R2 clear");
    bus_wr(4'h1, 32'h0000_0001, "R2 clear then");
    bus_wr(4'h0, 32'h0000_0001, "R1 set after clear");
    bus_rd(4'h2, "R1 R2 order latch");
    bus_wr(4'h6, 32'h0000_00FF, "R5 od enable");
    bus_rd(4'h8, "R5 od status");
    bus_wr(4'h2, 32'h0000_00F0, "R6 od pins mixed levels");
    bus_rd(4'h2, "R10 readback is latch");
    bus_rd(4'h7, "R10 unmapped reads zero");
    bus_wr(4'h7, 32'h0000_000F, "R5 od disable");
    bus_wr(4'hA, 32'h0F00_0000, "R11 oe disable");
    bus_rd(4'hB, "R11 oe status");
    bus_wr(4'h4, 32'h0000_FF00, "R4 mask disable");
    bus_rd(4'h5, "R4 mask status after disable");
    drive_pins(32'hFF00_FF00, 32'h5A00_3C00, 32'hF000_0F00, "R7 periph select");
    drive_pins(32'hFF00_FFF0, 32'hFFFF_FFF0, 32'hFFFF_FFFF, "R7 periph with od");
    bus_wr(4'h0, 32'h00FF_0000, "R8 set while periph");
    bus_wr(4'h1, 32'h0F00_0000, "R8 clear while periph");
    drive_pins(32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 back to gpio");
    settle();
    for (int k = 0; k < 400; k++) begin
      int op;
      logic [N-1:0] d;
      op = int'($urandom_range(0, 11));
      d = $urandom();
      case (op)
        0:  bus_wr(4'h0, d, "R1 rnd set");
        1:  bus_wr(4'h1, d, "R2 rnd clear");
        2:  bus_wr(4'h2, d, "R3 rnd data");
        3:  bus_wr(4'h3, d, "R4 rnd mask en");
        4:  bus_wr(4'h4, d, "R4 rnd mask dis");
        5:  bus_wr(4'h6, d, "R5 rnd od en");
        6:  bus_wr(4'h7, d, "R5 rnd od dis");
        7:  bus_wr(4'h9, d, "R11 rnd oe en");
        8:  bus_wr(4'hA, d, "R11 rnd oe dis");
        9:  drive_pins($urandom(), $urandom(), $urandom(), "R7 rnd periph");
        10: bus_rd(4'(2 + 3 * $urandom_range(0, 3)), "R10 rnd readback");
        default: bus_rd(4'(2 + 3 * $urandom_range(0, 3)), "R12 rnd read hold");
      endcase
    end
    settle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule